// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a countdown watchdog reached through a simple 32-bit register bus with word-aligned addresses. A prescaler divides the system clock down to a 1 MHz tick. While the watchdog runs, the live counter steps down by one on each tick. Software keeps the timer alive by writing a 16-bit key to the restart register. That write reloads the counter from the reload register.

When the counter runs out, the block stops and sets a timeout flag. It then emits one-cycle pulses for the actions that control enables: a system reset request, an interrupt and an external signal. When the reset action is enabled, it also drives a reset output for a programmable number of cycles. Keyed top-byte values on the reset-width register select the output polarity and whether it is push-pull or open drain. If a memory-controller reset is in progress at expiry, the block clears its control register and takes no action.

Top module: `kwdt_top`

## Requirements
- R1: After reset the counter and reload registers both read 0x014FB180, control reads 0x00000010, and reset width reads 0x000000FF. The flag, the three action pulses and the reset output enable are all low.
- R2: A write to offset 0x08 with bits [15:0] = 0x4755 loads the counter from reload, clears the timeout flag and runs the countdown if control bit 0 is set. Any other value changes nothing, and offset 0x08 reads 0.
- R3: A write to control (offset 0x0C) stores the data with bits [11:8] forced to 0 and bit 4 forced to 1.
- R4: A control write that takes bit 0 (enable) from 0 to 1 loads the counter from reload and starts the countdown.
- R5: A control write that takes enable from 1 to 0 stops the counter at its current value and clears the timeout flag. A control write that leaves enable at 1 does not reload the counter.
- R6: On the tick that finds the counter at 1 or 0, the counter goes to 0, the countdown stops and the timeout flag sets. For one cycle, sys_reset_req pulses if control bit 1 is set, wdt_irq if bit 2 is set, and wdt_ext if bit 3 is set. No further action follows until the next restart.
- R7: If mc_rst_busy is high at expiry, control becomes 0x00000000. No pulse is issued, the flag stays clear and the reset output stays idle.
- R8: A reset-width write (offset 0x18) always stores bits [19:0]. A top byte of 0xA5 sets bit 31 and 0x5A clears it. A top byte of 0xA8 sets bit 30 and 0x8A clears it. Any other top byte leaves bits 31:30 alone. Bits 29:20 read 0.
- R9: An expiry with control bit 1 set drives the reset output for width[19:0]+1 cycles with rst_oe=1 and rst_out = bit 31 (the active level). When idle, rst_out is the inverse of bit 31. rst_oe then stays high if bit 30 (push-pull) is set and is low otherwise (open drain).
- R10: Writes to the counter (offset 0x00) and writes at non-word-aligned addresses are ignored. Reads of unimplemented, out-of-range or misaligned offsets return 0.
- R11: A running counter steps down once every CLK_HZ/TICK_HZ cycles, with the first step that many cycles after the write that started or restarted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| mc_rst_busy | input | 1 | Memory-controller reset in progress |
| sys_reset_req | output | 1 | One-cycle system reset request at expiry |
| wdt_irq | output | 1 | One-cycle interrupt pulse at expiry |
| wdt_ext | output | 1 | One-cycle external signal pulse at expiry |
| timed_out | output | 1 | Timeout flag |
| rst_out | output | 1 | Reset output level |
| rst_oe | output | 1 | Reset output drive enable |

## Verification
The bench builds the block with CLK_HZ = 4000000 and TICK_HZ left at 1000000, so one tick spans four clocks. With small reload values, every step of the countdown, the expiry and the full reset pulse then fall inside a few dozen cycles and can be checked at the exact edge. RESET_LOAD keeps its default, so the reset value of the counter is checked as it stands.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int PW_BITS = 20;

    localparam logic [7:0] OFS_COUNT  = 8'h00;
    localparam logic [7:0] OFS_RELOAD = 8'h04;
    localparam logic [7:0] OFS_KICK   = 8'h08;
    localparam logic [7:0] OFS_CTRL   = 8'h0C;
    localparam logic [7:0] OFS_WIDTH  = 8'h18;

    localparam logic [15:0] KICK_KEY   = 16'h4755;
    localparam logic [7:0]  KEY_POL_HI = 8'hA5;
    localparam logic [7:0]  KEY_POL_LO = 8'h5A;
    localparam logic [7:0]  KEY_PP     = 8'hA8;
    localparam logic [7:0]  KEY_OD     = 8'h8A;

    localparam logic [31:0] CTRL_FORCE_ONE  = 32'h0000_0010;
    localparam logic [31:0] CTRL_FORCE_ZERO = 32'h0000_0F00;
    localparam logic [31:0] WIDTH_RST       = 32'h0000_00FF;

    typedef struct packed {
        logic [31:0] cnt;
        logic [31:0] reload;
        logic [31:0] ctrl;
        logic [31:0] width;
        logic        run;
        logic        flag;
        logic        irq;
        logic        ext;
        logic        sysrst;
    } core_st_t;
endpackage

// File: rtl/kwdt_tick.sv
module kwdt_tick #(
    parameter int DIV = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (clr || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R11: ticks never come on consecutive cycles
    a_r11_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] width,
    input  logic          pol_high,
    input  logic          push_pull,
    output logic          rst_out,
    output logic          rst_oe
);
    logic [PW:0] remain_d, remain_q;
    logic        active;

    assign active = (remain_q != '0);

    always_comb begin
        remain_d = remain_q;
        if (start) begin
            remain_d = {1'b0, width} + 1'b1;
        end else if (active) begin
            remain_d = remain_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else begin
            remain_q <= remain_d;
        end
    end

    assign rst_out = active ? pol_high : ~pol_high;
    assign rst_oe  = active | push_pull;

    // R9: the pulse length counts down one per cycle
    a_r9_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start) |=> (remain_q == $past(remain_q) - 1'b1));
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter logic [31:0] RESET_LOAD = 32'h014F_B180
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               tick,
    input  logic               mc_rst_busy,
    output logic               load_evt,
    output logic               fire_rst,
    output logic [PW_BITS-1:0] pulse_width,
    output logic               pol_high,
    output logic               push_pull,
    output logic               sys_reset_req,
    output logic               wdt_irq,
    output logic               wdt_ext,
    output logic               timed_out
);
    core_st_t d, q;
    logic     aligned;
    logic     wr_ok;
    logic     kick_hit;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr_ok    = bus_sel & bus_wr & aligned;
    assign kick_hit = wr_ok && (bus_addr == OFS_KICK) && (bus_wdata[15:0] == KICK_KEY);

    always_comb begin
        d        = q;
        d.irq    = 1'b0;
        d.ext    = 1'b0;
        d.sysrst = 1'b0;
        load_evt = 1'b0;
        fire_rst = 1'b0;

        if (q.run && tick) begin
            if (q.cnt <= 32'd1) begin
                d.cnt = '0;
                d.run = 1'b0;
                if (mc_rst_busy) begin
                    d.ctrl = '0;
                end else begin
                    d.flag   = 1'b1;
                    d.sysrst = q.ctrl[1];
                    d.irq    = q.ctrl[2];
                    d.ext    = q.ctrl[3];
                    fire_rst = q.ctrl[1];
                end
            end else begin
                d.cnt = q.cnt - 32'd1;
            end
        end

        if (wr_ok) begin
            case (bus_addr)
                OFS_RELOAD: d.reload = bus_wdata;
                OFS_KICK: begin
                    if (kick_hit) begin
                        d.cnt    = q.reload;
                        d.flag   = 1'b0;
                        d.run    = q.ctrl[0];
                        load_evt = 1'b1;
                    end
                end
                OFS_CTRL: begin
                    d.ctrl = (bus_wdata & ~CTRL_FORCE_ZERO) | CTRL_FORCE_ONE;
                    if (bus_wdata[0] && !q.ctrl[0]) begin
                        d.cnt    = q.reload;
                        d.run    = 1'b1;
                        load_evt = 1'b1;
                    end else if (!bus_wdata[0] && q.ctrl[0]) begin
                        d.run  = 1'b0;
                        d.flag = 1'b0;
                    end
                end
                OFS_WIDTH: begin
                    d.width[PW_BITS-1:0] = bus_wdata[PW_BITS-1:0];
                    case (bus_wdata[31:24])
                        KEY_POL_HI: d.width[31] = 1'b1;
                        KEY_POL_LO: d.width[31] = 1'b0;
                        KEY_PP:     d.width[30] = 1'b1;
                        KEY_OD:     d.width[30] = 1'b0;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt    <= RESET_LOAD;
            q.reload <= RESET_LOAD;
            q.ctrl   <= CTRL_FORCE_ONE;
            q.width  <= WIDTH_RST;
            q.run    <= 1'b0;
            q.flag   <= 1'b0;
            q.irq    <= 1'b0;
            q.ext    <= 1'b0;
            q.sysrst <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && aligned) begin
            case (bus_addr)
                OFS_COUNT:  bus_rdata = q.cnt;
                OFS_RELOAD: bus_rdata = q.reload;
                OFS_CTRL:   bus_rdata = q.ctrl;
                OFS_WIDTH:  bus_rdata = q.width;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign pulse_width   = q.width[PW_BITS-1:0];
    assign pol_high      = q.width[31];
    assign push_pull     = q.width[30];
    assign sys_reset_req = q.sysrst;
    assign wdt_irq       = q.irq;
    assign wdt_ext       = q.ext;
    assign timed_out     = q.flag;

    // R2: a keyed restart loads the counter from reload
    a_r2_restart_loads: assert property (@(posedge clk) disable iff (!rst_n)
        $past(kick_hit) |-> (q.cnt == $past(q.reload)));

    // R4: the countdown always starts from the reload value
    a_r4_start_from_reload: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.run) |-> (q.cnt == $past(q.reload)));

    // R6: the interrupt is a single-cycle pulse
    a_r6_single_irq: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |=> !q.irq);

    // R6: the timeout flag rises only with the countdown stopped
    a_r6_stopped_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flag) |-> !q.run);

    // R7: no action is issued while a memory-controller reset is busy
    a_r7_no_action_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (q.irq || q.sysrst || q.ext) |-> !$past(mc_rst_busy));
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
    parameter int          CLK_HZ     = 24_000_000,
    parameter int          TICK_HZ    = 1_000_000,
    parameter logic [31:0] RESET_LOAD = 32'h014F_B180
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        mc_rst_busy,
    output logic        sys_reset_req,
    output logic        wdt_irq,
    output logic        wdt_ext,
    output logic        timed_out,
    output logic        rst_out,
    output logic        rst_oe
);
    import kwdt_pkg::*;

    localparam int DIV = CLK_HZ / TICK_HZ;

    generate
        if (DIV < 2) begin : g_bad_div
            $error("kwdt_top: CLK_HZ must be at least twice TICK_HZ");
        end
    endgenerate

    logic               tick;
    logic               load_evt;
    logic               fire_rst;
    logic [PW_BITS-1:0] pulse_width;
    logic               pol_high;
    logic               push_pull;

    kwdt_tick #(.DIV(DIV)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load_evt),
        .tick  (tick)
    );

    kwdt_core #(.RESET_LOAD(RESET_LOAD)) i_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .tick          (tick),
        .mc_rst_busy   (mc_rst_busy),
        .load_evt      (load_evt),
        .fire_rst      (fire_rst),
        .pulse_width   (pulse_width),
        .pol_high      (pol_high),
        .push_pull     (push_pull),
        .sys_reset_req (sys_reset_req),
        .wdt_irq       (wdt_irq),
        .wdt_ext       (wdt_ext),
        .timed_out     (timed_out)
    );

    kwdt_pulse #(.PW(PW_BITS)) i_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fire_rst),
        .width     (pulse_width),
        .pol_high  (pol_high),
        .push_pull (push_pull),
        .rst_out   (rst_out),
        .rst_oe    (rst_oe)
    );
endmodule

// File: tb/test_kwdt_top.sv
`timescale 1ns/1ps
module test_kwdt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mc_rst_busy = 1'b0;
    logic        sys_reset_req, wdt_irq, wdt_ext, timed_out, rst_out, rst_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 1'b0;

    always #2 clk = ~clk;

    kwdt_top #(.CLK_HZ(4_000_000), .TICK_HZ(1_000_000)) i_kwdt_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .mc_rst_busy   (mc_rst_busy),
        .sys_reset_req (sys_reset_req),
        .wdt_irq       (wdt_irq),
        .wdt_ext       (wdt_ext),
        .timed_out     (timed_out),
        .rst_out       (rst_out),
        .rst_oe        (rst_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [7:0] a, input logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        brd(a, v);
        chk(req, v, exp);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic t_reset();
        rd_chk("R1 count", 8'h00, 32'h014F_B180);
        rd_chk("R1 reload", 8'h04, 32'h014F_B180);
        rd_chk("R1 ctrl", 8'h0C, 32'h0000_0010);
        rd_chk("R1 width", 8'h18, 32'h0000_00FF);
        chk("R1 outputs idle", {28'd0, timed_out, wdt_irq, sys_reset_req, rst_oe}, 32'd0);
        rd_chk("R2 restart reads 0", 8'h08, 32'd0);
    endtask

    task automatic t_ctrl_sanitize();
        bwr(8'h0C, 32'hFFFF_FFEE);
        rd_chk("R3 forced bits", 8'h0C, 32'hFFFF_F0FE);
        bwr(8'h0C, 32'h0000_0000);
        rd_chk("R3 forced one", 8'h0C, 32'h0000_0010);
    endtask

    task automatic t_ignored();
        bwr(8'h00, 32'h0000_1234);
        rd_chk("R10 count write ignored", 8'h00, 32'h014F_B180);
        bwr(8'h05, 32'h0000_0007);
        rd_chk("R10 misaligned write ignored", 8'h04, 32'h014F_B180);
        rd_chk("R10 unimpl read", 8'h10, 32'd0);
        rd_chk("R10 mask read", 8'h1C, 32'd0);
        rd_chk("R10 out of range", 8'h40, 32'd0);
        rd_chk("R10 misaligned read", 8'h05, 32'd0);
    endtask

    task automatic t_count();
        bwr(8'h04, 32'd5);
        bwr(8'h0C, 32'h11);
        rd_chk("R4 load on enable", 8'h00, 32'd5);
        step(3);
        rd_chk("R11 no step early", 8'h00, 32'd5);
        step(1);
        rd_chk("R11 first step", 8'h00, 32'd4);
        step(4);
        rd_chk("R11 second step", 8'h00, 32'd3);
        bwr(8'h0C, 32'h10);
        step(10);
        rd_chk("R5 stop holds", 8'h00, 32'd3);
        bwr(8'h0C, 32'h11);
        rd_chk("R4 reload on re-enable", 8'h00, 32'd5);
        step(4);
        rd_chk("R4 running", 8'h00, 32'd4);
        bwr(8'h0C, 32'h13);
        rd_chk("R5 no reload when enable kept", 8'h00, 32'd4);
        step(3);
        rd_chk("R5 still counting", 8'h00, 32'd3);
        bwr(8'h0C, 32'h10);
    endtask

    task automatic t_kick();
        bwr(8'h04, 32'd5);
        bwr(8'h0C, 32'h11);
        step(5);
        rd_chk("R2 pre-kick", 8'h00, 32'd4);
        bwr(8'h08, 32'h0000_4756);
        rd_chk("R2 wrong key ignored", 8'h00, 32'd4);
        bwr(8'h08, 32'hABCD_4755);
        rd_chk("R2 key reloads", 8'h00, 32'd5);
        step(3);
        rd_chk("R11 restart phase", 8'h00, 32'd5);
        step(1);
        rd_chk("R11 step after restart", 8'h00, 32'd4);
        bwr(8'h0C, 32'h10);
        bwr(8'h04, 32'd9);
        bwr(8'h08, 32'h0000_4755);
        rd_chk("R2 kick while disabled loads", 8'h00, 32'd9);
        step(8);
        rd_chk("R2 kick while disabled stays", 8'h00, 32'd9);
    endtask

    task automatic t_expire();
        bwr(8'h18, 32'hA500_0002);
        rd_chk("R8 pol high key", 8'h18, 32'h8000_0002);
        bwr(8'h04, 32'd3);
        bwr(8'h0C, 32'h1F);
        step(11);
        rd_chk("R6 before expiry", 8'h00, 32'd1);
        chk("R6 quiet before", {28'd0, timed_out, wdt_irq, sys_reset_req, rst_oe}, 32'd0);
        step(1);
        rd_chk("R6 count zero", 8'h00, 32'd0);
        chk("R6 actions", {26'd0, timed_out, wdt_irq, wdt_ext, sys_reset_req, rst_oe, rst_out},
            32'b11_1111);
        step(1);
        chk("R6 single pulse", {29'd0, wdt_irq, wdt_ext, sys_reset_req}, 32'd0);
        chk("R9 pulse cycle 2", {30'd0, rst_oe, rst_out}, 32'b11);
        step(1);
        chk("R9 pulse cycle 3", {30'd0, rst_oe, rst_out}, 32'b11);
        step(1);
        chk("R9 open drain release", {30'd0, rst_oe, rst_out}, 32'b00);
        step(20);
        rd_chk("R6 stays stopped", 8'h00, 32'd0);
        chk("R6 flag held", {31'd0, timed_out}, 32'd1);
        bwr(8'h08, 32'h0000_4755);
        chk("R2 kick clears flag", {31'd0, timed_out}, 32'd0);
        rd_chk("R2 kick reloads after expiry", 8'h00, 32'd3);
        bwr(8'h0C, 32'h10);
    endtask

    task automatic t_busy();
        logic seen;
        seen = 1'b0;
        mc_rst_busy = 1'b1;
        bwr(8'h04, 32'd2);
        bwr(8'h0C, 32'h1F);
        step(7);
        for (int i = 0; i < 4; i++) begin
            step(1);
            seen = seen | wdt_irq | wdt_ext | sys_reset_req | rst_oe | timed_out;
        end
        chk("R7 no action", {31'd0, seen}, 32'd0);
        rd_chk("R7 ctrl cleared", 8'h0C, 32'd0);
        rd_chk("R7 count zero", 8'h00, 32'd0);
        mc_rst_busy = 1'b0;
    endtask

    task automatic t_push_pull();
        bwr(8'h18, 32'h5A00_0001);
        rd_chk("R8 pol low key", 8'h18, 32'h0000_0001);
        bwr(8'h18, 32'hA800_0001);
        rd_chk("R8 push-pull key", 8'h18, 32'h4000_0001);
        bwr(8'h18, 32'h12FF_FFF3);
        rd_chk("R8 other key keeps bits", 8'h18, 32'h400F_FFF3);
        bwr(8'h18, 32'h8A00_0001);
        rd_chk("R8 open drain key", 8'h18, 32'h0000_0001);
        bwr(8'h18, 32'hA800_0001);
        chk("R9 push-pull idle", {30'd0, rst_oe, rst_out}, 32'b11);
        bwr(8'h04, 32'd1);
        bwr(8'h0C, 32'h13);
        step(3);
        chk("R9 before expiry", {30'd0, rst_oe, rst_out}, 32'b11);
        step(1);
        chk("R9 active low drive", {30'd0, rst_oe, rst_out}, 32'b10);
        chk("R6 irq off when disabled", {30'd0, wdt_irq, timed_out}, 32'b01);
        step(1);
        chk("R9 second cycle", {30'd0, rst_oe, rst_out}, 32'b10);
        step(1);
        chk("R9 back to inactive", {30'd0, rst_oe, rst_out}, 32'b11);
        bwr(8'h0C, 32'h12);
        chk("R5 disable clears flag", {31'd0, timed_out}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_sanitize();
        t_ignored();
        t_count();
        t_kick();
        t_expire();
        t_busy();
        t_push_pull();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end
endmodule